// File: doc/BRIEF.md
# Spread-Spectrum Differential PWM Modulator

This block turns signed audio samples into the two logic-level drive signals of a filterless bridge-tied speaker stage. Each switching period is built from an up/down count. The "P" output is high for a window centred in the period whose width grows with the sample. The "N" output uses the complementary width. With a zero sample the two outputs are identical square waves at 50% duty. The load therefore sees no differential voltage and little idle current.

The period length is set by the parameter `NOM_HALF`, the half-period in clock cycles. The default of 84 gives a switching period of 168 cycles, about 300 kHz from a 50 MHz clock. To spread the switching energy across the spectrum, the half-period is swept in a triangle around `NOM_HALF`. The swing of the sweep follows a spread percentage input, so the average frequency stays at the nominal value. A new sample, a new spread setting and the next period length are all taken only at the boundary between periods. The pulse shape therefore never changes in the middle of a period.

Top module: `spread_pwm_mod`

## Requirements
- R1: While `rstN` is low both outputs are low. The first period starts at the first rising clock edge at which `rstN` is high. That period uses half-period `NOM_HALF` and the idle width `NOM_HALF/2` on both outputs.
- R2: A period with half-period h lasts exactly 2h clock cycles, indexed 0 to 2h-1. After the edge that ends index 2h-1, the next period begins at index 0.
- R3: In a period with half-period h and width w, an output is high exactly on indices h-w through h+w-1. The high window is therefore centred on the middle of the period.
- R4: The width of P is floor(h*(2^(W-1)+d)/2^W), clamped to h. Here d is the signed two's-complement sample of W = `SAMPLE_W` bits, so P's duty is 50% + d/2 of full scale.
- R5: The width of N is floor(h*(2^(W-1)-d)/2^W), clamped to h.
- R6: With a zero sample, P and N are equal on every cycle of the period and each is high for exactly h cycles. This holds whenever h is even, which is always the case for even `NOM_HALF`.
- R7: At the most negative sample, P stays low for the whole period and N stays high for the whole period. At the most positive sample, N's width is floor(h/2^W) and P's width is floor(h*(2^W-1)/2^W).
- R8: A sample is captured only on a clock edge with `sampleValid` high, and the last captured sample wins. The captured sample is applied at the next period boundary. Input changes without `sampleValid` have no effect.
- R9: The spread setting is sampled at each period boundary. It is clamped to `MAX_PCT`, and then gives a swing of dev = 2*floor(`NOM_HALF`*pct/200) cycles.
- R10: At each boundary a half-period offset is updated as follows. If dev = 0 the offset becomes 0 and the sweep direction becomes upward. Otherwise, if offset >= dev the offset becomes dev-2 and the direction turns downward. If offset <= -dev the offset becomes -dev+2 and the direction turns upward. In all other cases the offset moves by 2 in the current direction. The new period uses h = `NOM_HALF` + offset. After reset the offset is 0 and the direction is upward.
- R11: A zero spread setting gives h = `NOM_HALF` from the very next period, whatever the previous offset was.
- R12: With a constant non-zero spread, the lengths of any 2*dev consecutive periods sum to 2*dev*2*`NOM_HALF`. The average frequency is therefore the nominal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | SAMPLE_W | Signed audio sample |
| sampleValid | input | 1 | Capture strobe for `sampleIn` |
| spreadPct | input | PCT_W | Spread percentage, clamped to `MAX_PCT` |
| drvP | output | 1 | Positive-side PWM drive |
| drvN | output | 1 | Negative-side PWM drive |

## Verification
The bench sweeps every sample code of a 6-bit build and compares each cycle of each period against the window computed from the width formulas.
- An off-by-one in the up/down count, or a width taken with the wrong half-period, would shift or stretch the window by a cycle.
- Full-scale codes test that the widths reach 0 and h without wrapping; a wrapping width would show short pulses where the output should be flat.
- The spread is switched while the sweep sits at its peak, over-ranged values are applied, and the spread is cut to zero mid-sweep. An unclamped offset or a missing turnaround would produce period lengths outside the swing.
- The spacing between P's rising edges over a full sweep must add up to the nominal total; a biased triangle would pull the average frequency away from nominal.

// File: rtl/pwm_spread_pkg.sv
package pwm_spread_pkg;

  // Strobes handed from the period controller to the pulse datapath.
  typedef struct packed {
    logic periodLoad;   // last cycle of the period: widths reload on this edge
    logic secondHalf;   // counting down the second half of the period
  } pwmStrobe_t;

  function automatic int calcDevMax(input int nomHalf, input int maxPct);
    return 2 * ((nomHalf * maxPct) / 200);
  endfunction

  function automatic int calcHalfMax(input int nomHalf, input int maxPct);
    return nomHalf + calcDevMax(nomHalf, maxPct);
  endfunction

endpackage

// File: rtl/pwm_spread_ctrl.sv
module pwm_spread_ctrl
  import pwm_spread_pkg::*;
#(
  parameter int NOM_HALF = 84,
  parameter int MAX_PCT  = 30,
  parameter int PCT_W    = 7,
  localparam int DEV_MAX  = calcDevMax(NOM_HALF, MAX_PCT),
  localparam int HALF_MAX = calcHalfMax(NOM_HALF, MAX_PCT),
  localparam int HW       = $clog2(HALF_MAX + 1),
  localparam int CW       = $clog2(2 * HALF_MAX + 1),
  localparam int OW       = HW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PCT_W-1:0] spreadPct,
  output pwmStrobe_t       strobe,
  output logic [CW-1:0]    idx,
  output logic [HW-1:0]    curHalf,
  output logic [HW-1:0]    nextHalf
);

  logic [CW-1:0]        idxQ;
  logic [HW-1:0]        halfQ;
  logic signed [OW-1:0] offQ;
  logic                 upQ;

  logic [PCT_W-1:0]     pctClamp;
  logic signed [OW-1:0] devS;
  logic signed [OW-1:0] offNext;
  logic                 upNext;
  logic [CW-1:0]        lastIdx;
  logic                 periodEnd;

  // Swing for the coming period, from the clamped spread setting.
  always_comb begin
    pctClamp = (spreadPct > PCT_W'(MAX_PCT)) ? PCT_W'(MAX_PCT) : spreadPct;
    devS     = OW'(2 * ((NOM_HALF * int'(pctClamp)) / 200));
  end

  // Triangle sweep of the half-period offset.
  always_comb begin
    offNext = offQ;
    upNext  = upQ;
    if (devS == '0) begin
      offNext = '0;
      upNext  = 1'b1;
    end else if (offQ >= devS) begin
      offNext = devS - OW'(2);
      upNext  = 1'b0;
    end else if (offQ <= -devS) begin
      offNext = -devS + OW'(2);
      upNext  = 1'b1;
    end else if (upQ) begin
      offNext = offQ + OW'(2);
    end else begin
      offNext = offQ - OW'(2);
    end
    nextHalf = HW'(NOM_HALF + int'(offNext));
  end

  always_comb begin
    lastIdx   = CW'({halfQ, 1'b0}) - CW'(1);
    periodEnd = (idxQ == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      halfQ <= HW'(NOM_HALF);
      offQ  <= '0;
      upQ   <= 1'b1;
    end else if (periodEnd) begin
      idxQ  <= '0;
      halfQ <= nextHalf;
      offQ  <= offNext;
      upQ   <= upNext;
    end else begin
      idxQ  <= idxQ + CW'(1);
    end
  end

  assign strobe.periodLoad = periodEnd;
  assign strobe.secondHalf = (idxQ >= CW'(halfQ));
  assign idx     = idxQ;
  assign curHalf = halfQ;

  // R2: the index never passes the end of the current period
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    idxQ < CW'({halfQ, 1'b0}));

  // R2: the period length only changes at a period boundary
  a_r2_half_hold: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> $stable(halfQ));

  // R10: the half-period stays inside the largest swing
  a_r10_half_range: assert property (@(posedge clk) disable iff (!rstN)
    (halfQ >= HW'(NOM_HALF - DEV_MAX)) && (halfQ <= HW'(HALF_MAX)));

  // R11: a zero spread at the boundary yields the nominal half-period
  a_r11_zero_spread_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && spreadPct == '0) |=> (halfQ == HW'(NOM_HALF)));

endmodule

// File: rtl/pwm_pulse_dp.sv
module pwm_pulse_dp
  import pwm_spread_pkg::*;
#(
  parameter int NOM_HALF = 84,
  parameter int MAX_PCT  = 30,
  parameter int SAMPLE_W = 16,
  localparam int HALF_MAX   = calcHalfMax(NOM_HALF, MAX_PCT),
  localparam int HW         = $clog2(HALF_MAX + 1),
  localparam int CW         = $clog2(2 * HALF_MAX + 1),
  localparam int PW         = HW + SAMPLE_W + 1,
  localparam int HALF_SCALE = 2 ** (SAMPLE_W - 1),
  localparam int NLEG       = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  pwmStrobe_t                 strobe,
  input  logic [CW-1:0]              idx,
  input  logic [HW-1:0]              curHalf,
  input  logic [HW-1:0]              nextHalf,
  output logic                       drvP,
  output logic                       drvN
);

  logic signed [SAMPLE_W-1:0] sampleHoldQ;
  logic signed [SAMPLE_W-1:0] activeQ;
  logic [SAMPLE_W:0]          bias [NLEG];
  logic [CW-1:0]              carrier;
  logic [NLEG-1:0]            drvVec;
  logic [HW-1:0]              widthVec [NLEG];

  // Sample capture on the strobe; handed to the period only at its boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleHoldQ <= '0;
      activeQ     <= '0;
    end else begin
      if (sampleValid)       sampleHoldQ <= sampleIn;
      if (strobe.periodLoad) activeQ     <= sampleHoldQ;
    end
  end

  // Offset-binary numerators: leg 0 is half scale plus d, leg 1 half scale minus d.
  always_comb begin
    bias[0] = {1'b0, ~sampleHoldQ[SAMPLE_W-1], sampleHoldQ[SAMPLE_W-2:0]};
    bias[1] = (SAMPLE_W + 1)'(HALF_SCALE) - {sampleHoldQ[SAMPLE_W-1], sampleHoldQ};
  end

  // Up/down carrier position within the period.
  always_comb begin
    if (strobe.secondHalf) carrier = CW'({curHalf, 1'b0}) - CW'(1) - idx;
    else                   carrier = idx;
  end

  for (genvar leg = 0; leg < NLEG; leg++) begin : g_leg
    logic [PW-1:0] prod;
    logic [PW-1:0] full;
    logic [HW-1:0] widthNext;
    logic [HW-1:0] widthQ;
    logic          drvQ;

    always_comb begin
      prod      = PW'(nextHalf) * PW'(bias[leg]);
      full      = prod >> SAMPLE_W;
      widthNext = (full > PW'(nextHalf)) ? nextHalf : full[HW-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        widthQ <= HW'(NOM_HALF / 2);
        drvQ   <= 1'b0;
      end else begin
        drvQ <= (carrier >= CW'(curHalf - widthQ));
        if (strobe.periodLoad) widthQ <= widthNext;
      end
    end

    assign drvVec[leg]   = drvQ;
    assign widthVec[leg] = widthQ;
  end

  assign drvP = drvVec[0];
  assign drvN = drvVec[1];

  // R4: P's width never exceeds the half-period
  a_r4_width_cap_p: assert property (@(posedge clk) disable iff (!rstN)
    widthVec[0] <= curHalf);

  // R5: N's width never exceeds the half-period
  a_r5_width_cap_n: assert property (@(posedge clk) disable iff (!rstN)
    widthVec[1] <= curHalf);

  // R4: the two widths are computed apart yet together fill h or h-1
  a_r4_width_sum: assert property (@(posedge clk) disable iff (!rstN)
    ((HW + 1)'(widthVec[0]) + (HW + 1)'(widthVec[1]) <= (HW + 1)'(curHalf)) &&
    ((HW + 1)'(widthVec[0]) + (HW + 1)'(widthVec[1]) + (HW + 1)'(1) >= (HW + 1)'(curHalf)));

  // R6: an idle period drives both outputs in phase
  a_r6_idle_in_phase: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ == '0) |=> (drvP == drvN));

  // R8: the held sample moves only on a valid strobe
  a_r8_hold_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sampleHoldQ));

  // R8: the applied sample moves only at a period boundary
  a_r8_apply_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.periodLoad |=> $stable(activeQ));

endmodule

// File: rtl/spread_pwm_mod.sv
module spread_pwm_mod
  import pwm_spread_pkg::*;
#(
  parameter int NOM_HALF = 84,
  parameter int SAMPLE_W = 16,
  parameter int PCT_W    = 7,
  parameter int MAX_PCT  = 30,
  localparam int HALF_MAX = calcHalfMax(NOM_HALF, MAX_PCT),
  localparam int HW       = $clog2(HALF_MAX + 1),
  localparam int CW       = $clog2(2 * HALF_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic [PCT_W-1:0]           spreadPct,
  output logic                       drvP,
  output logic                       drvN
);

  pwmStrobe_t    strobe;
  logic [CW-1:0] idx;
  logic [HW-1:0] curHalf;
  logic [HW-1:0] nextHalf;

  pwm_spread_ctrl #(
    .NOM_HALF (NOM_HALF),
    .MAX_PCT  (MAX_PCT),
    .PCT_W    (PCT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .spreadPct (spreadPct),
    .strobe    (strobe),
    .idx       (idx),
    .curHalf   (curHalf),
    .nextHalf  (nextHalf)
  );

  pwm_pulse_dp #(
    .NOM_HALF (NOM_HALF),
    .MAX_PCT  (MAX_PCT),
    .SAMPLE_W (SAMPLE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sampleIn    (sampleIn),
    .sampleValid (sampleValid),
    .strobe      (strobe),
    .idx         (idx),
    .curHalf     (curHalf),
    .nextHalf    (nextHalf),
    .drvP        (drvP),
    .drvN        (drvN)
  );

endmodule

// File: tb/spread_pwm_mod_tb.sv
module spread_pwm_mod_tb;

  localparam int NOM  = 16;
  localparam int SW   = 6;
  localparam int PW   = 6;
  localparam int MAXP = 40;
  localparam int HS   = 1 << (SW - 1);
  localparam int FS   = 1 << SW;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic signed [SW-1:0] sampleIn = '0;
  logic                 sampleValid = 1'b0;
  logic [PW-1:0]        spreadPct = '0;
  logic                 drvP;
  logic                 drvN;

  int total = 0;
  int bad = 0;

  // Expected state of the current period.
  int mH = NOM, mWP = NOM / 2, mWN = NOM / 2, mOff = 0, mUp = 1, curSample = 0;
  int gCyc = 0;
  logic prevP = 1'b0;
  int riseAt [0:511];
  int riseCount = 0;

  always #10 clk = ~clk;

  spread_pwm_mod #(
    .NOM_HALF (NOM),
    .SAMPLE_W (SW),
    .PCT_W    (PW),
    .MAX_PCT  (MAXP)
  ) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .sampleIn    (sampleIn),
    .sampleValid (sampleValid),
    .spreadPct   (spreadPct),
    .drvP        (drvP),
    .drvN        (drvN)
  );

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // Next period per R9/R10, widths per R4/R5.
  task automatic updateModel(input int s, input int pct);
    int pc, dev;
    pc  = (pct > MAXP) ? MAXP : pct;
    dev = 2 * ((NOM * pc) / 200);
    if (dev == 0) begin
      mOff = 0; mUp = 1;
    end else if (mOff >= dev) begin
      mOff = dev - 2; mUp = 0;
    end else if (mOff <= -dev) begin
      mOff = -dev + 2; mUp = 1;
    end else begin
      mOff = mUp ? mOff + 2 : mOff - 2;
    end
    mH  = NOM + mOff;
    mWP = (mH * (HS + s)) / FS;
    mWN = (mH * (HS - s)) / FS;
    if (mWP > mH) mWP = mH;
    if (mWN > mH) mWN = mH;
    curSample = s;
  endtask

  // Checks one period cycle by cycle and stages the inputs for the next one.
  task automatic doPeriod(input int nextSample, input int nextPct, input bit dbl, input string tag);
    int badP = 0, badN = 0, badZ = 0, hiP = 0;
    int fiP = 0, fiN = 0;
    logic faP = 1'b0, feP = 1'b0, faN = 1'b0, feN = 1'b0;
    logic expP, expN;
    logic signed [SW-1:0] junk;
    junk = ~SW'(nextSample);
    for (int i = 0; i < 2 * mH; i++) begin
      @(negedge clk);
      gCyc++;
      expP = (i >= mH - mWP) && (i < mH + mWP);
      expN = (i >= mH - mWN) && (i < mH + mWN);
      if (drvP !== expP) begin
        if (badP == 0) begin fiP = i; faP = drvP; feP = expP; end
        badP++;
      end
      if (drvN !== expN) begin
        if (badN == 0) begin fiN = i; faN = drvN; feN = expN; end
        badN++;
      end
      if (drvP === 1'b1) hiP++;
      if (drvP !== drvN) badZ++;
      if (drvP === 1'b1 && prevP === 1'b0 && riseCount < 512) begin
        riseAt[riseCount] = gCyc;
        riseCount++;
      end
      prevP = drvP;
      if (i == 1) begin
        sampleIn    = dbl ? junk : SW'(nextSample);
        sampleValid = 1'b1;
        spreadPct   = PW'(nextPct);
      end else if (i == 2) begin
        if (dbl) begin
          sampleIn    = SW'(nextSample);
          sampleValid = 1'b1;
        end else begin
          sampleIn    = junk;
          sampleValid = 1'b0;
        end
      end else if (i == 3) begin
        sampleIn    = junk;
        sampleValid = 1'b0;
      end
    end
    check(badP == 0, $sformatf("%s R2 R3 R4 P-wave d=%0d h=%0d idx=%0d actual=%b expected=%b",
                               tag, curSample, mH, fiP, faP, feP));
    check(badN == 0, $sformatf("%s R2 R3 R5 N-wave d=%0d h=%0d idx=%0d actual=%b expected=%b",
                               tag, curSample, mH, fiN, faN, feN));
    if (curSample == 0)
      check(badZ == 0 && hiP == mH,
            $sformatf("R6 idle h=%0d mismatches actual=%0d expected=0 highCycles actual=%0d expected=%0d",
                      mH, badZ, hiP, mH));
    updateModel(nextSample, nextPct);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int guard;
    int span;
    // R1: outputs low while in reset
    repeat (4) @(negedge clk);
    check(drvP === 1'b0 && drvN === 1'b0,
          $sformatf("R1 reset outputs actual=%b%b expected=00", drvP, drvN));
    rstN = 1'b1;  // at a falling edge: the next rising edge opens period 0

    // R1: nominal idle first period
    doPeriod(0, 0, 0, "R1");

    // R4 R5 R11: every sample code with no spread
    for (int d = -HS; d < HS; d++) doPeriod(d, 0, 0, "R4 R11");
    doPeriod(0, 0, 0, "R4 R11");

    // R7: full-scale codes under spread
    doPeriod(-HS, 40, 0, "R7");
    doPeriod(HS - 1, 40, 0, "R7");
    doPeriod(0, 40, 0, "R7");

    // R12: constant spread, idle sample, triangle of eight periods
    for (int k = 0; k < 24; k++) doPeriod(0, 25, 0, "R6 R10");
    span = riseAt[riseCount - 1] - riseAt[riseCount - 9];
    check(span == 8 * 2 * NOM,
          $sformatf("R12 cycles over one sweep actual=%0d expected=%0d", span, 8 * 2 * NOM));

    // R9: over-range spread clamps to the maximum
    for (int k = 0; k < 30; k++) doPeriod(((k * 7) % FS) - HS, 63, 0, "R9");

    // R10: shrink the swing while the sweep sits at its peak
    guard = 0;
    while (mOff != 6 && guard < 20) begin
      doPeriod(5, 40, 0, "R10");
      guard++;
    end
    check(mOff == 6, $sformatf("R10 sweep peak reached actual=%0d expected=6", mOff));
    doPeriod(5, 25, 0, "R10");
    for (int k = 0; k < 10; k++) doPeriod(-9 + k, 25, 0, "R10");

    // R11: spread cut to zero mid-sweep
    doPeriod(3, 0, 0, "R11");
    doPeriod(-3, 0, 0, "R11");
    doPeriod(0, 0, 0, "R11");

    // R8: two captures in one period, last one wins; stray input ignored
    doPeriod(17, 0, 1, "R8");
    doPeriod(-20, 40, 1, "R8");
    doPeriod(11, 40, 0, "R8");
    doPeriod(0, 40, 1, "R8");
    doPeriod(0, 0, 0, "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule